// File: doc/BRIEF.md
# Dual-Channel Converter Serial Readout Port

This block is the digital side of a two-channel converter's serial output port, written as a synthesizable behavioural model that runs on a fast system clock. An active-low convert-start pin starts a conversion. The block then holds `busy` high for a fixed number of system clock cycles. When `busy` falls, it captures the two parallel results presented on its input ports. The analog conversion itself is represented only by those inputs.

A host reads the captured words through an active-low chip select and a serial clock. All three pins are asynchronous to the system clock, so they are synchronised and edge-detected. Each channel has its own data output, and each data output has an enable that stands in for a three-state pad.

After a channel's own word, a pin continues with the other channel's word, so a single pin can carry both results. Chip select may fall before the conversion ends, or it may be held low permanently. In both cases the most significant bit appears as soon as the results are captured.

Top module: `dual_adc_serial_port`

## Requirements
- R1: A falling edge on `cnv_n` while idle raises `busy` for exactly CONV_CYCLES system clock cycles. A further falling edge while `busy` is high is ignored and does not lengthen the conversion.
- R2: `res_a` and `res_b` are captured in the cycle in which the conversion ends. Changes to them at any other time do not alter the word that is shifted out.
- R3: A falling edge on `cs_n` sets `oe_a` and `oe_b`. It also presents bit N-1 of channel A on `dout_a` and bit N-1 of channel B on `dout_b`, where N is DATA_W.
- R4: Each `sclk` falling edge while `cs_n` is low and `busy` is low presents the next lower bit, MSB first.
- R5: An `sclk` falling edge that reaches the block in the same system cycle as the `cs_n` falling edge is not counted. The MSB stays on the pins until the next `sclk` falling edge.
- R6: After the N bits of its own channel, `dout_a` continues with channel B's word MSB first, and `dout_b` continues with channel A's word MSB first.
- R7: Once 2N bits have been presented, both data outputs drive 0 until `cs_n` rises.
- R8: A rising edge on `cs_n` clears `oe_a` and `oe_b`. The next `cs_n` falling edge restarts the readout at the MSB.
- R9: If `cs_n` falls during a conversion, the enables are set at once. `sclk` edges are ignored while `busy` is high. The new MSB appears on both pins within two system cycles of `busy` falling.
- R10: If `cs_n` is held low permanently, the enables never clear. Each conversion presents its MSB within two system cycles of `busy` falling, and the following `sclk` falling edge presents the next bit.
- R11: While an enable is low, its data output drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_n | input | 1 | Active-low convert start, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| res_a | input | DATA_W | Parallel result of channel A |
| res_b | input | DATA_W | Parallel result of channel B |
| busy | output | 1 | High while a conversion runs |
| dout_a | output | 1 | Serial data, channel A first |
| dout_b | output | 1 | Serial data, channel B first |
| oe_a | output | 1 | Drive enable for `dout_a` |
| oe_b | output | 1 | Drive enable for `dout_b` |

## Verification
The assertions assume that every pin level lasts at least two system cycles, so that each host edge is seen once after the synchroniser. They also assume that a serial clock falling edge is matched to a chip-select falling edge only when both pins change in the same instant. The bench keeps every `sclk` phase at three or more system cycles and every `cs_n` level at six or more. It changes `sclk` and `cs_n` together only in the dedicated coincidence case. It samples outputs a fixed margin after each pin change, so the margin covers the synchroniser delay.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  // Synchronised pin events passed from the input stage to the shifter
  typedef struct packed {
    logic cs_low;
    logic cs_fall;
    logic cs_rise;
    logic sclk_fall;
    logic cnv_fall;
  } pin_events_t;
endpackage

// File: rtl/dsp_pin_sync.sv
module dsp_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= {STAGES{RST_VAL[g]}};
        prev <= RST_VAL[g];
      end else begin
        sh   <= {sh[STAGES-2:0], pin[g]};
        prev <= sh[LAST];
      end
    end
    assign lvl[g]  = sh[LAST];
    assign fall[g] = prev & ~sh[LAST];
    assign rise[g] = ~prev & sh[LAST];
  end
endmodule

// File: rtl/dsp_conv_timer.sv
module dsp_conv_timer #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] lat_a,
  output logic [DATA_W-1:0] lat_b
);
  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      lat_a <= '0;
      lat_b <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= CW'(CONV_CYCLES - 1);
        end
      end else if (cnt == '0) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        lat_a <= res_a;
        lat_b <= res_b;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // Independent window counter for the conversion length check
  logic [CW:0] win;
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= busy ? win + 1'b1 : '0;
  end

  // R1
  busy_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> win == (CW+1)'(CONV_CYCLES));
  // R1
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R2
  capture_on_end_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(lat_a) && $stable(lat_b)));
endmodule

// File: rtl/dsp_out_shifter.sv
module dsp_out_shifter
  import dsp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_events_t       ev,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] lat_a,
  input  logic [DATA_W-1:0] lat_b,
  output logic              dout_a,
  output logic              dout_b,
  output logic              oe_a,
  output logic              oe_b
);
  localparam int TOT = 2 * DATA_W;
  localparam int BW  = $clog2(TOT + 1);

  logic [BW-1:0]  cnt, cnt_nx;
  logic           oe_nx;
  logic [TOT-1:0] word_a, word_b;

  assign word_a = {lat_a, lat_b};
  assign word_b = {lat_b, lat_a};

  function automatic logic pick(input logic [TOT-1:0] w, input logic [BW-1:0] idx);
    int p;
    p = TOT - 1 - int'(idx);
    return (int'(idx) < TOT) ? w[p] : 1'b0;
  endfunction

  always_comb begin
    cnt_nx = cnt;
    oe_nx  = oe_a;
    if (ev.cs_fall) begin
      oe_nx  = 1'b1;
      cnt_nx = '0;
    end else if (ev.cs_rise) begin
      oe_nx  = 1'b0;
    end else if (ev.sclk_fall && ev.cs_low && !busy && cnt != BW'(TOT)) begin
      cnt_nx = cnt + 1'b1;
    end
    if (done) cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      oe_a   <= 1'b0;
      oe_b   <= 1'b0;
      dout_a <= 1'b0;
      dout_b <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      oe_a   <= oe_nx;
      oe_b   <= oe_nx;
      dout_a <= oe_nx & pick(word_a, cnt_nx);
      dout_b <= oe_nx & pick(word_b, cnt_nx);
    end
  end

  // R3
  cs_fall_enables_chk: assert property (@(posedge clk) disable iff (rst)
    ev.cs_fall |=> (oe_a && oe_b));
  // R5
  coincident_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.cs_fall && ev.sclk_fall && !done) |=> cnt == '0);
  // R8
  cs_rise_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.cs_rise && !ev.cs_fall) |=> (!oe_a && !oe_b));
  // R9
  busy_freezes_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ev.sclk_fall && !ev.cs_fall) |=> $stable(cnt));
  // R7
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == BW'(TOT)) |-> (!dout_a && !dout_b));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_a |-> (!dout_a && !dout_b));
endmodule

// File: rtl/dual_adc_serial_port.sv
module dual_adc_serial_port
  import dsp_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  output logic              busy,
  output logic              dout_a,
  output logic              dout_b,
  output logic              oe_a,
  output logic              oe_b
);
  // bit 0: convert start, bit 1: chip select, bit 2: serial clock
  logic [2:0]  lvl, fall, rise;
  pin_events_t ev;
  logic        done;
  logic [DATA_W-1:0] lat_a, lat_b;

  dsp_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst), .pin({sclk, cs_n, cnv_n}),
    .lvl(lvl), .fall(fall), .rise(rise)
  );

  assign ev.cs_low    = ~lvl[1];
  assign ev.cs_fall   = fall[1];
  assign ev.cs_rise   = rise[1];
  assign ev.sclk_fall = fall[2];
  assign ev.cnv_fall  = fall[0];

  dsp_conv_timer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(ev.cnv_fall), .res_a(res_a), .res_b(res_b),
    .busy(busy), .done(done), .lat_a(lat_a), .lat_b(lat_b)
  );

  dsp_out_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .ev(ev), .busy(busy), .done(done),
    .lat_a(lat_a), .lat_b(lat_b),
    .dout_a(dout_a), .dout_b(dout_b), .oe_a(oe_a), .oe_b(oe_b)
  );
endmodule

// File: tb/dual_adc_serial_port_bench.sv
`timescale 1ns/1ps
module dual_adc_serial_port_bench;
  localparam int DW   = 12;
  localparam int CONV = 40;
  localparam int TOT  = 2 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv_n = 1'b1, cs_n = 1'b1, sclk = 1'b0;
  logic [DW-1:0] res_a = '0, res_b = '0;
  logic busy, dout_a, dout_b, oe_a, oe_b;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0;
  int oe_drops = 0;

  always #2 clk = ~clk;

  dual_adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) u_dual_adc_serial_port (
    .clk(clk), .rst(rst), .cnv_n(cnv_n), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .busy(busy),
    .dout_a(dout_a), .dout_b(dout_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  always @(negedge clk) if (mon_en && (!oe_a || !oe_b)) oe_drops++;

  function automatic logic exp_bit(input logic [DW-1:0] a, input logic [DW-1:0] b, input int i);
    if (i < DW)  return a[DW-1-i];
    if (i < TOT) return b[TOT-1-i];
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; waitn(3);
    sclk = 1'b0; waitn(6);
  endtask

  task automatic convert(input logic [DW-1:0] a, input logic [DW-1:0] b);
    res_a = a; res_b = b;
    cnv_n = 1'b0; waitn(3); cnv_n = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    waitn(3);
  endtask

  task automatic check_bit(input logic [DW-1:0] a, input logic [DW-1:0] b, input int i, input string req);
    chk(dout_a == exp_bit(a, b, i), req, dout_a, exp_bit(a, b, i));
    chk(dout_b == exp_bit(b, a, i), req, dout_b, exp_bit(b, a, i));
  endtask

  task automatic read_frame(input logic [DW-1:0] a, input logic [DW-1:0] b);
    cs_n = 1'b0; waitn(6);
    chk(oe_a && oe_b, "R3 enables", {oe_a, oe_b}, 3);
    check_bit(a, b, 0, "R3 msb");
    for (int i = 1; i < TOT + 3; i++) begin
      pulse_sclk();
      if (i < DW)       check_bit(a, b, i, "R4 own word");
      else if (i < TOT) check_bit(a, b, i, "R6 chained word");
      else              check_bit(a, b, i, "R7 tail zero");
    end
    cs_n = 1'b1; waitn(6);
    chk(!oe_a && !oe_b, "R8 enables clear", {oe_a, oe_b}, 0);
    chk(!dout_a && !dout_b, "R11 idle zero", {dout_a, dout_b}, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, old_a, old_b;
    int cyc;
    waitn(4); rst = 1'b0; waitn(4);
    chk(!busy && !oe_a && !oe_b && !dout_a && !dout_b, "R11 reset state",
        {busy, oe_a, oe_b, dout_a, dout_b}, 0);

    // R1: conversion length, with a second start pulse ignored mid-conversion
    res_a = 12'h123; res_b = 12'h456;
    cnv_n = 1'b0; waitn(3); cnv_n = 1'b1;
    while (!busy) @(negedge clk);
    cyc = 0;
    fork
      begin while (busy) begin cyc++; @(negedge clk); end end
      begin waitn(8); cnv_n = 1'b0; waitn(3); cnv_n = 1'b1; end
    join
    chk(cyc == CONV, "R1 busy length", cyc, CONV);
    waitn(12);
    chk(!busy, "R1 no restart", busy, 0);

    // R2, R4, R6, R7, R8 over a sweep of result words
    for (int k = 0; k < 8; k++) begin
      a = (k == 0) ? '1 : DW'(k * 1237 + 5);
      b = (k == 0) ? '0 : DW'((k * 2741) ^ 12'hA5C);
      convert(a, b);
      res_a = ~a; res_b = ~b;   // R2: post-capture changes must not show
      read_frame(a, b);
    end

    // R5: sclk falls in the same instant as cs_n
    sclk = 1'b1; waitn(6);
    a = 12'hB3C; b = 12'h4D2;
    convert(a, b);
    cs_n = 1'b0; sclk = 1'b0; waitn(6);
    check_bit(a, b, 0, "R5 coincident edge ignored");
    pulse_sclk();
    check_bit(a, b, 1, "R5 next edge counted");
    cs_n = 1'b1; waitn(6);

    // R9: chip select low before the conversion ends
    old_a = a; old_b = b;
    a = 12'h9E1; b = 12'h35F;
    cs_n = 1'b0; waitn(6);
    chk(oe_a && oe_b, "R9 early enables", {oe_a, oe_b}, 3);
    res_a = a; res_b = b;
    cnv_n = 1'b0; waitn(3); cnv_n = 1'b1;
    while (!busy) @(negedge clk);
    pulse_sclk(); pulse_sclk();
    chk(busy, "R9 still busy", busy, 1);
    while (busy) @(negedge clk);
    waitn(2);
    check_bit(a, b, 0, "R9 msb at busy fall");
    pulse_sclk();
    check_bit(a, b, 1, "R9 second bit");
    cs_n = 1'b1; waitn(6);

    // R10: chip select held low across conversions
    cs_n = 1'b0; waitn(6);
    mon_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      a = DW'(k * 911 + 1638); b = DW'(k * 577 + 2211);
      res_a = a; res_b = b;
      cnv_n = 1'b0; waitn(3); cnv_n = 1'b1;
      while (!busy) @(negedge clk);
      while (busy) @(negedge clk);
      waitn(2);
      check_bit(a, b, 0, "R10 msb at busy fall");
      for (int i = 1; i < 4; i++) begin
        pulse_sclk();
        check_bit(a, b, i, "R10 following bit");
      end
    end
    mon_en = 1'b0;
    chk(oe_drops == 0, "R10 enables held", oe_drops, 0);
    cs_n = 1'b1; waitn(6);
    chk(!oe_a && !dout_a, "R8 release", {oe_a, dout_a}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule